// File: doc/BRIEF.md
# Pulse-Width Coded Serial Programming Port

This block is the digital end of a one-wire programming port. The supply pin reaches it as a single logic level. A bit is coded in how a fixed-rate pulse divides its period: a high that fills most of the period is a one, and a high that fills only a small part is a zero. The block decides each bit by comparing the measured high and low times. It collects the bits least significant first. It closes a word when the low level lasts much longer than any bit low. It keeps only the most recent fourteen bits, which are thirteen data bits followed by a stop bit. For every pulse it receives, it drives one bit of a parallel transmit word onto the output pin.

After reset the block releases the output pin, so the pin floats high, and watches the pin for a limited window. If an external tester holds the pin low long enough, the port opens a session. If the fuses are already programmed, or the window passes without such a low, the block gives up the pin for good and passes the normal sensor output through. A session ends with a high level that lasts far longer than any bit high. Only a new reset can open the port again.

Top module: `pwsp_top`

## Requirements
- R1: After reset, `q_out` is 1 (pin released), `test_mode` is 0 and `rx_stb` is 0. The entry window lasts ENTRY_WIN_TICKS clock cycles from reset.
- R2: When `pin_sense` stays low for ENTRY_LOW_TICKS consecutive cycles, a session opens (`test_mode` = 1). The low must begin inside the window, and may run on past the end of the window. A shorter low opens nothing. A low that begins after the window opens nothing.
- R3: While `programmed` is 1, no session can open. The block enters normal operation at once.
- R4: Outside a session, `q_out` equals `sensor_q`, and pulses on `sup_lvl` produce no strobe.
- R5: A bit is 1 when its high time, counted in cycles, is strictly greater than its low time. In other words, the high must be longer than half the measured period. A tie decodes as 0. The rule holds for any period length.
- R6: Bits are sent least significant first. `rx_word` bit i is the i-th data bit received. The fourteenth bit is the stop bit and is dropped.
- R7: A low that lasts EOW_TICKS cycles after a pulse ends the word, and the pending bit then decodes as 0. If at least 14 bits have arrived, `rx_stb` pulses for one cycle with the new `rx_word`. If fewer have arrived, there is no strobe and `rx_word` keeps its value.
- R8: When more than 14 bits arrive in one word, only the last 14 are used.
- R9: During the high of pulse k of a word (k counted from 0), `q_out` carries bit k of `tx_word`, which is sampled at the first pulse. From pulse 13 on, `q_out` is 1. Between words, `q_out` is 1.
- R10: Once the session has seen a low, a high that lasts EOC_TICKS cycles ends the session. No session can open again until reset.
- R11: `rx_word` changes only in a cycle where `rx_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sup_lvl | input | 1 | Supply-pin level after voltage detection |
| pin_sense | input | 1 | Level read back from the output pin |
| programmed | input | 1 | Fuses already programmed; blocks entry |
| sensor_q | input | 1 | Normal sensor output level |
| tx_word | input | DATA_W | Data to return during a word |
| q_out | output | 1 | Output pin level (1 = released) |
| test_mode | output | 1 | Programming session open |
| rx_word | output | DATA_W | Last complete received word |
| rx_stb | output | 1 | One-cycle strobe for a new word |

## Verification
Some properties are checked on every cycle. The pin stays released during the watch phase. A session never opens when the fuses are programmed, and never opens again after one has closed. Strobes are single cycles and occur only inside a session, and the received word moves only with its strobe. The bench scenarios cover what needs an intended stimulus to observe. These include the pulse ratio decision at the tie and off-tie points and at several periods, least-significant-first assembly and the overwrite of older bits, and words too short to strobe. They also include the per-pulse output data, and the entry window cases: a short low, a late low, and a low that runs past the window.

// File: rtl/pwsp_pkg.sv
package pwsp_pkg;

   typedef enum logic [1:0] {
      MODE_WATCH   = 2'd0,
      MODE_NORMAL  = 2'd1,
      MODE_SESSION = 2'd2
   } mode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwsp_sync.sv
module pwsp_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2+1-1:0], d} >> 0;
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwsp_entry.sv
module pwsp_entry #(
   parameter int LOW_TICKS = 1760,
   parameter int WIN_TICKS = 3520,
   parameter int EW        = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic watch,
   input  logic pin_low,
   output logic hit,
   output logic expire
);

   localparam logic [EW-1:0] LOW_M1 = EW'(LOW_TICKS - 1);
   localparam logic [EW-1:0] WIN_M1 = EW'(WIN_TICKS - 1);

   logic [EW-1:0] win_cnt;
   logic [EW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         low_cnt <= '0;
      end else if (!watch) begin
         win_cnt <= '0;
         low_cnt <= '0;
      end else begin
         if (win_cnt != '1) win_cnt <= win_cnt + 1'b1;
         if (!pin_low)             low_cnt <= '0;
         else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
      end
   end

   // a low already in progress keeps the window open until it resolves
   assign hit    = watch & pin_low & (low_cnt == LOW_M1);
   assign expire = watch & ~pin_low & (win_cnt >= WIN_M1);

endmodule

// File: rtl/pwsp_bitdec.sv
module pwsp_bitdec #(
   parameter int EOW_TICKS = 440,
   parameter int EOC_TICKS = 880,
   parameter int CW        = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sup,
   output logic bit_start,
   output logic bit_vld,
   output logic bit_val,
   output logic eow,
   output logic eoc
);

   localparam logic [CW-1:0] EOW_M1 = CW'(EOW_TICKS - 1);
   localparam logic [CW-1:0] EOC_M1 = CW'(EOC_TICKS - 1);

   logic          sup_q;
   logic          have_hi;
   logic          armed;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] lo_cnt;
   logic          rise;

   assign rise      = en & sup & ~sup_q;
   assign bit_start = rise;
   assign eow       = en & ~sup & have_hi & (lo_cnt == EOW_M1);
   assign eoc       = en & sup & ~rise & armed & (hi_cnt == EOC_M1);
   assign bit_vld   = (rise & have_hi) | eow;
   // high longer than low is the same as high longer than half the period
   assign bit_val   = rise & (hi_cnt > lo_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_q   <= 1'b1;
         have_hi <= 1'b0;
         armed   <= 1'b0;
         hi_cnt  <= '0;
         lo_cnt  <= '0;
      end else begin
         sup_q <= sup;
         if (!en) begin
            have_hi <= 1'b0;
            armed   <= 1'b0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
         end else if (rise) begin
            hi_cnt  <= CW'(1);
            lo_cnt  <= '0;
            have_hi <= 1'b1;
         end else if (sup) begin
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            armed <= 1'b1;
            if (have_hi) begin
               if (eow)                 have_hi <= 1'b0;
               else if (lo_cnt != '1)   lo_cnt  <= lo_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pwsp_frame.sv
module pwsp_frame #(
   parameter int DATA_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              bit_start,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              eow,
   input  logic [DATA_W-1:0] tx_word,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_stb,
   output logic              q_dat
);

   localparam int FRAME_W = DATA_W + 1;
   localparam int IW      = $clog2(FRAME_W + 1);
   localparam logic [IW-1:0] FULL = IW'(FRAME_W);
   localparam logic [IW-1:0] NDAT = IW'(DATA_W);

   logic [FRAME_W-1:0] sh, sh_nxt;
   logic [IW-1:0]      nbits, n_nxt;
   logic [IW-1:0]      idx;
   logic               word_open;
   logic [DATA_W-1:0]  tx_buf, tx_sh;

   always_comb begin
      sh_nxt = sh;
      n_nxt  = nbits;
      if (bit_vld) begin
         sh_nxt = {bit_val, sh[FRAME_W-1:1]};
         if (nbits != FULL) n_nxt = nbits + 1'b1;
      end
   end

   assign tx_sh = tx_buf >> idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         nbits     <= '0;
         idx       <= '0;
         word_open <= 1'b0;
         tx_buf    <= '0;
         q_dat     <= 1'b1;
         rx_word   <= '0;
         rx_stb    <= 1'b0;
      end else if (!en) begin
         sh        <= '0;
         nbits     <= '0;
         idx       <= '0;
         word_open <= 1'b0;
         q_dat     <= 1'b1;
         rx_stb    <= 1'b0;
      end else begin
         sh     <= sh_nxt;
         nbits  <= n_nxt;
         rx_stb <= 1'b0;
         if (eow) begin
            word_open <= 1'b0;
            q_dat     <= 1'b1;
            nbits     <= '0;
            if (n_nxt == FULL) begin
               rx_stb  <= 1'b1;
               rx_word <= sh_nxt[DATA_W-1:0];
            end
         end else if (bit_start) begin
            if (!word_open) begin
               word_open <= 1'b1;
               tx_buf    <= tx_word;
               idx       <= IW'(1);
               q_dat     <= tx_word[0];
            end else begin
               q_dat <= (idx < NDAT) ? tx_sh[0] : 1'b1;
               if (idx != FULL) idx <= idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pwsp_top.sv
module pwsp_top #(
   parameter int DATA_W          = 13,
   parameter int EOW_TICKS       = 440,
   parameter int EOC_TICKS       = 880,
   parameter int ENTRY_LOW_TICKS = 1760,
   parameter int ENTRY_WIN_TICKS = 3520,
   parameter int SYNC_STAGES     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup_lvl,
   input  logic              pin_sense,
   input  logic              programmed,
   input  logic              sensor_q,
   input  logic [DATA_W-1:0] tx_word,
   output logic              q_out,
   output logic              test_mode,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_stb
);
   import pwsp_pkg::*;

   localparam int CW = $clog2(max_u(EOW_TICKS, EOC_TICKS) + 1) + 1;
   localparam int EW = $clog2(max_u(ENTRY_LOW_TICKS, ENTRY_WIN_TICKS) + 1) + 1;

   generate
      if (DATA_W < 1 || DATA_W > 30) begin : g_bad_w
         $error("DATA_W out of range");
      end
      if (EOW_TICKS < 2 || EOC_TICKS < 2) begin : g_bad_t
         $error("end thresholds must be at least 2 cycles");
      end
      if (ENTRY_LOW_TICKS < 1 || ENTRY_WIN_TICKS < 1) begin : g_bad_e
         $error("entry thresholds must be positive");
      end
      if (SYNC_STAGES > 4) begin : g_bad_s
         $error("SYNC_STAGES above 4");
      end
   endgenerate

   mode_e mode_q;
   logic  sup_s, pin_s;
   logic  hit, expire;
   logic  bit_start, bit_vld, bit_val, eow, eoc;
   logic  q_dat;
   logic  in_session;

   pwsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sup (
      .clk(clk), .rst_n(rst_n), .d(sup_lvl), .q(sup_s));

   pwsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pin (
      .clk(clk), .rst_n(rst_n), .d(pin_sense), .q(pin_s));

   pwsp_entry #(.LOW_TICKS(ENTRY_LOW_TICKS), .WIN_TICKS(ENTRY_WIN_TICKS), .EW(EW)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .watch((mode_q == MODE_WATCH) & ~programmed),
      .pin_low(~pin_s), .hit(hit), .expire(expire));

   assign in_session = (mode_q == MODE_SESSION);

   pwsp_bitdec #(.EOW_TICKS(EOW_TICKS), .EOC_TICKS(EOC_TICKS), .CW(CW)) u_bitdec (
      .clk(clk), .rst_n(rst_n), .en(in_session), .sup(sup_s),
      .bit_start(bit_start), .bit_vld(bit_vld), .bit_val(bit_val),
      .eow(eow), .eoc(eoc));

   pwsp_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(in_session),
      .bit_start(bit_start), .bit_vld(bit_vld), .bit_val(bit_val), .eow(eow),
      .tx_word(tx_word), .rx_word(rx_word), .rx_stb(rx_stb), .q_dat(q_dat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_WATCH;
      else begin
         unique case (mode_q)
            MODE_WATCH: begin
               if (programmed)  mode_q <= MODE_NORMAL;
               else if (hit)    mode_q <= MODE_SESSION;
               else if (expire) mode_q <= MODE_NORMAL;
            end
            MODE_SESSION: if (eoc) mode_q <= MODE_NORMAL;
            default:      mode_q <= MODE_NORMAL;
         endcase
      end
   end

   always_comb begin
      unique case (mode_q)
         MODE_WATCH:   q_out = 1'b1;
         MODE_SESSION: q_out = q_dat;
         default:      q_out = sensor_q;
      endcase
   end

   assign test_mode = in_session;

endmodule

// File: rtl/pwsp_chk.sv
module pwsp_chk #(
   parameter int DATA_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              programmed,
   input logic              q_out,
   input logic              test_mode,
   input logic [DATA_W-1:0] rx_word,
   input logic              rx_stb,
   input pwsp_pkg::mode_e   mode
);

   logic left;
   logic tm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= 1'b0;
         tm_q <= 1'b0;
      end else begin
         tm_q <= test_mode;
         if (tm_q && !test_mode) left <= 1'b1;
      end
   end

   // R1: pin stays released while watching for entry
   p_watch_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == pwsp_pkg::MODE_WATCH) |-> q_out);

   // R3: a session never opens when the fuses are programmed
   p_entry_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_mode) |-> !$past(programmed));

   // R7: strobes appear only inside a session
   p_stb_in_session_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |-> test_mode);

   // R7: a strobe lasts one cycle
   p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |=> !rx_stb);

   // R11: the received word moves only with its strobe
   p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> rx_stb);

   // R10: no second session before reset
   p_no_reentry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      left |-> !test_mode);

endmodule

bind pwsp_top pwsp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .programmed(programmed), .q_out(q_out),
   .test_mode(test_mode), .rx_word(rx_word), .rx_stb(rx_stb), .mode(mode_q));

// File: tb/tb_pwsp_top.sv
module tb_pwsp_top;

   localparam int DW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sup_lvl = 1'b1;
   logic          force_low = 1'b0;
   logic          programmed = 1'b0;
   logic          sensor_q = 1'b0;
   logic [DW-1:0] tx_word = '0;
   logic          pin_sense;
   logic          q_out, test_mode, rx_stb;
   logic [DW-1:0] rx_word;

   int n_chk = 0;
   int n_err = 0;
   int stb_cnt = 0;
   logic [DW-1:0] cap_word = '0;

   always #2 clk = ~clk;

   assign pin_sense = force_low ? 1'b0 : q_out;

   pwsp_top dut (
      .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl), .pin_sense(pin_sense),
      .programmed(programmed), .sensor_q(sensor_q), .tx_word(tx_word),
      .q_out(q_out), .test_mode(test_mode), .rx_word(rx_word), .rx_stb(rx_stb));

   always @(negedge clk) begin
      if (rst_n && rx_stb) begin
         stb_cnt  = stb_cnt + 1;
         cap_word = rx_word;
      end
   end

   // rows: {bit count[8], tx word[16], sent bits, first sent at bit 0 [32]}
   localparam logic [55:0] VEC [7] = '{
      {8'd14, 16'h1234, 32'h00000ABC},
      {8'd14, 16'h1FFF, 32'h00001FFF},
      {8'd14, 16'h0000, 32'h00000000},
      {8'd17, 16'h0AAA, 32'h0000AAAF},
      {8'd10, 16'h0F0F, 32'h000003FF},
      {8'd14, 16'h1555, 32'h00001F05},
      {8'd20, 16'h0001, 32'h0003C3FF}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; force_low = 1'b0; sup_lvl = 1'b1;
      cyc(5);
      rst_n = 1'b1;
   endtask

   // one pulse; q_out checked mid-high against the expected return bit
   task automatic send_bit(input int hi, input int lo, input bit chk_q, input bit exp_q);
      sup_lvl = 1'b1;
      cyc(hi / 2);
      if (chk_q) chk(q_out == exp_q, "R9 return bit", q_out, exp_q);
      cyc(hi - hi / 2);
      sup_lvl = 1'b0;
      cyc(lo);
   endtask

   task automatic start_word();
      sup_lvl = 1'b0;
      cyc(100);
   endtask

   task automatic end_word();
      sup_lvl = 1'b0;
      cyc(600);
   endtask

   task automatic enter_session();
      do_reset();
      programmed = 1'b0;
      cyc(20);
      force_low = 1'b1;
      cyc(1800);
      force_low = 1'b0;
      cyc(10);
   endtask

   initial begin : main
      int s0;
      logic [DW-1:0] keep;

      // reset state
      rst_n = 1'b0;
      cyc(3);
      chk(q_out == 1'b1, "R1 released in reset", q_out, 1);
      chk(test_mode == 1'b0, "R1 no session in reset", test_mode, 0);
      chk(rx_stb == 1'b0, "R1 no strobe in reset", rx_stb, 0);
      rst_n = 1'b1;
      cyc(10);
      chk(q_out == 1'b1, "R1 released while watching", q_out, 1);

      // window passes with no low: normal pass-through, later low ignored
      cyc(3600);
      sensor_q = 1'b0;
      cyc(2);
      chk(test_mode == 1'b0, "R1 window expiry", test_mode, 0);
      chk(q_out == 1'b0, "R4 pass-through low", q_out, 0);
      sensor_q = 1'b1;
      cyc(2);
      chk(q_out == 1'b1, "R4 pass-through high", q_out, 1);
      force_low = 1'b1; cyc(1900); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b0, "R2 low after window", test_mode, 0);
      s0 = stb_cnt;
      start_word();
      for (int k = 0; k < 14; k++) send_bit(200, 100, 1'b0, 1'b0);
      end_word();
      chk(stb_cnt == s0, "R4 pulses ignored outside session", stb_cnt - s0, 0);

      // short low then a full low, both inside the window
      do_reset();
      cyc(10);
      force_low = 1'b1; cyc(1000); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b0, "R2 short low", test_mode, 0);
      force_low = 1'b1; cyc(1800); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b1, "R2 full low enters", test_mode, 1);

      // low begun late in the window runs past its end
      do_reset();
      cyc(3000);
      force_low = 1'b1; cyc(1800); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b1, "R2 low across window end", test_mode, 1);

      // programmed part
      do_reset();
      programmed = 1'b1;
      sensor_q = 1'b0;
      force_low = 1'b1; cyc(2000); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b0, "R3 programmed blocks entry", test_mode, 0);
      chk(q_out == 1'b0, "R3 normal output", q_out, 0);
      programmed = 1'b0;

      // vector table
      enter_session();
      for (int r = 0; r < 7; r++) begin
         int            n;
         logic [31:0]   pat;
         logic [DW-1:0] tx, exp_w;
         n   = int'(VEC[r][55:48]);
         tx  = VEC[r][DW+31:32];
         pat = VEC[r][31:0];
         exp_w = '0;
         for (int i = 0; i < DW; i++) if (n >= 14) exp_w[i] = pat[n - 14 + i];
         keep = cap_word;
         s0 = stb_cnt;
         tx_word = tx;
         start_word();
         for (int k = 0; k < n; k++) begin
            if (pat[k]) send_bit(200, 100, 1'b1, (k < DW) ? tx[k] : 1'b1);
            else        send_bit(100, 200, 1'b1, (k < DW) ? tx[k] : 1'b1);
         end
         end_word();
         chk(q_out == 1'b1, "R9 idle between words", q_out, 1);
         if (n >= 14) begin
            chk(stb_cnt == s0 + 1, "R7 strobe per word", stb_cnt - s0, 1);
            chk(cap_word == exp_w, (n > 14) ? "R8 last bits kept" : "R6 LSB-first word",
                cap_word, exp_w);
         end else begin
            chk(stb_cnt == s0, "R7 short word no strobe", stb_cnt - s0, 0);
            chk(rx_word == keep, "R11 word held", rx_word, keep);
         end
      end

      // ratio decisions at varied periods, tie included
      s0 = stb_cnt;
      start_word();
      send_bit(151, 149, 1'b0, 1'b0);
      send_bit(150, 150, 1'b0, 1'b0);
      send_bit(100, 300, 1'b0, 1'b0);
      send_bit(250, 150, 1'b0, 1'b0);
      send_bit(60, 40, 1'b0, 1'b0);
      send_bit(40, 60, 1'b0, 1'b0);
      for (int k = 6; k < 14; k++) send_bit(100, 200, 1'b0, 1'b0);
      end_word();
      chk(stb_cnt == s0 + 1, "R5 ratio word strobe", stb_cnt - s0, 1);
      chk(cap_word == 13'h0019, "R5 ratio decisions", cap_word, 13'h0019);

      // end of session
      sensor_q = 1'b1;
      sup_lvl = 1'b1;
      cyc(1000);
      chk(test_mode == 1'b0, "R10 long high ends session", test_mode, 0);
      chk(q_out == 1'b1, "R10 output back to sensor", q_out, 1);
      s0 = stb_cnt;
      start_word();
      for (int k = 0; k < 14; k++) send_bit(200, 100, 1'b0, 1'b0);
      end_word();
      chk(stb_cnt == s0, "R10 no decode after end", stb_cnt - s0, 0);
      force_low = 1'b1; cyc(1900); force_low = 1'b0; cyc(10);
      chk(test_mode == 1'b0, "R10 no re-entry", test_mode, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule